// File: doc/BRIEF.md
# Receive Frame Buffer with Host Block-Read Port

This block captures one received management frame into a byte store and hands it to a host over a command-decoded register set. A frame writer on the receive side strobes in bytes, then marks the end of the frame with a strobe that carries framing-error and checksum-error flags. When the frame is complete, the block locks the store, raises a done flag and an optional interrupt, and waits for the host. No later frame can overwrite the store until the host re-arms it.

The host works through byte commands. Each command carries a register code, and that code is the register's address. A block read on the data port returns a byte count first. That count is capped at a chunk of 32. The data bytes follow, and they keep coming past the chunk until the host sends a NACK. A read pointer supplies the data address. The pointer advances by one on every data byte, and the host can also set it directly, so the frame can be read as a stream or from any chosen position.

Top module: `rxbuf_top`

## Requirements
- R1: After reset, status (code 0x3D) reads 0x80, the interrupt register (0x3C) reads 0x00, the length registers (0x3E low byte, 0x3A bit 0 = bit 8) read 0, the read pointer (0x3F) reads 0, and `irq` is 0.
- R2: At a frame end, the block sets receive-done, clears receive-enable (status bit 7), and stores the number of bytes captured as the length. Status bit 0 holds the framing error, bit 1 the checksum error and bit 2 the OR of the two.
- R3: `irq` is 1 exactly when the control register (0x3B, reset 0) has bit 7 set and either receive-done is set with mask bit 0 clear or transmit-done is set with mask bit 1 clear.
- R4: Reading 0x3C returns bit 0 = receive-done, bit 1 = transmit-done and bit 7 = their OR. The read then clears both done bits, so `irq` drops.
- R5: While receive-enable is 0, incoming bytes and frame ends are ignored. Stored data, length and status stay unchanged.
- R6: Writing 0x3D with bit 7 = 1 sets receive-enable, clears the error bits and clears the read pointer. A write with bit 7 = 0 has no effect.
- R7: The read pointer can be written through 0x3F. It increments once per data byte returned and wraps modulo 256.
- R8: A block read (op 2) with code 0x40 returns, on its first byte request, the count min(32, length − pointer), or 0 when the pointer is at or past the length. Each later request returns the stored byte at the pointer.
- R9: Data keeps flowing past 32 bytes until `host_nack`. The next block read resumes from the current pointer and computes its count afresh.
- R10: The store holds 256 bytes. A longer frame keeps its first 256 bytes, sets the framing error and reports length 256.
- R11: A byte read (op 0) answers with `rsp_valid` one cycle after the command. A write (op 1) or the start of a block read gives no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_vld | input | 1 | Received byte strobe |
| rx_byte | input | 8 | Received byte |
| rx_end | input | 1 | End-of-frame strobe |
| rx_fram_err | input | 1 | Framing error, valid with rx_end |
| rx_fcs_err | input | 1 | Checksum error, valid with rx_end |
| tx_done | input | 1 | Transmit-done pulse from the transmit path |
| cmd_valid | input | 1 | Host command strobe |
| cmd_op | input | 2 | 0 read byte, 1 write byte, 2 block read |
| cmd_code | input | 8 | Register code (address) |
| cmd_wdata | input | 8 | Write data |
| byte_req | input | 1 | Request the next block-read byte |
| host_nack | input | 1 | End the current block read |
| rsp_valid | output | 1 | Response byte valid |
| rsp_data | output | 8 | Response byte |
| irq | output | 1 | Interrupt request |

## Verification
A corrupted write counter or a broken lock shows up at the next block read: the stored bytes no longer match the frame that was sent, or the length register changes after a frame that arrives while the buffer is locked. A read pointer that misses an increment returns a repeated byte or a wrong chunk count as soon as the next block starts. Faults in the done, mask or enable bits show up on `irq` in the cycle after the frame-end strobe, or on the status and interrupt reads that follow.

// File: rtl/rxbuf_pkg.sv
package rxbuf_pkg;
  typedef enum logic [1:0] {
    OP_RD  = 2'd0,
    OP_WR  = 2'd1,
    OP_BLK = 2'd2
  } host_op_e;

  localparam logic [7:0] A_LENHI = 8'h3A;
  localparam logic [7:0] A_CTRL  = 8'h3B;
  localparam logic [7:0] A_INT   = 8'h3C;
  localparam logic [7:0] A_STAT  = 8'h3D;
  localparam logic [7:0] A_LENLO = 8'h3E;
  localparam logic [7:0] A_ADDR  = 8'h3F;
  localparam logic [7:0] A_DATA  = 8'h40;

  localparam int unsigned CTRL_GIE = 7;
  localparam int unsigned CTRL_RXM = 0;
  localparam int unsigned CTRL_TXM = 1;
endpackage

// File: rtl/rxbuf_store.sv
module rxbuf_store #(
  parameter int unsigned DEPTH = 256,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned LW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm,
  input  logic          in_vld,
  input  logic [7:0]    in_byte,
  input  logic          in_end,
  input  logic          in_fram,
  input  logic          in_fcs,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_byte,
  output logic          end_pulse,
  output logic [LW-1:0] end_len,
  output logic          end_fram,
  output logic          end_fcs
);
  logic [LW-1:0] cnt_q, cnt_n;
  logic          ovf_q, ovf_n;
  logic          room;
  logic          mem_we;
  logic [7:0]    mem [DEPTH];

  assign room   = cnt_q < LW'(DEPTH);
  assign mem_we = arm && in_vld && !in_end && room;

  always_comb begin
    cnt_n = cnt_q;
    ovf_n = ovf_q;
    if (arm) begin
      if (in_end) begin
        cnt_n = '0;
        ovf_n = 1'b0;
      end else if (in_vld) begin
        if (room) cnt_n = cnt_q + LW'(1);
        else      ovf_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      cnt_q <= cnt_n;
      ovf_q <= ovf_n;
    end
  end

  always_ff @(posedge clk) begin
    if (mem_we) mem[cnt_q[AW-1:0]] <= in_byte;
  end

  assign rd_byte   = mem[rd_addr];
  assign end_pulse = arm && in_end;
  assign end_len   = cnt_q;
  assign end_fram  = in_fram || ovf_q;
  assign end_fcs   = in_fcs;

  // R10: the capture count never passes the store size
  p_cap_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LW'(DEPTH));
  // R5: a locked store keeps its capture count
  p_lock_cnt_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !arm |=> $stable(cnt_q));
endmodule

// File: rtl/rxbuf_regs.sv
module rxbuf_regs
  import rxbuf_pkg::*;
#(
  parameter int unsigned DEPTH = 256,
  parameter int unsigned CHUNK = 32,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned LW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [1:0]    cmd_op,
  input  logic [7:0]    cmd_code,
  input  logic [7:0]    cmd_wdata,
  input  logic          byte_req,
  input  logic          host_nack,
  input  logic          tx_done_set,
  input  logic          end_pulse,
  input  logic [LW-1:0] end_len,
  input  logic          end_fram,
  input  logic          end_fcs,
  input  logic [7:0]    mem_byte,
  output logic          rx_en,
  output logic [AW-1:0] rd_addr,
  output logic          rsp_valid,
  output logic [7:0]    rsp_data,
  output logic          irq
);
  logic [7:0]    ctrl_q, ctrl_n;
  logic          rxd_q, rxd_n, txd_q, txd_n;
  logic          en_q, en_n, fram_q, fram_n, fcs_q, fcs_n;
  logic [LW-1:0] len_q, len_n;
  logic [AW-1:0] addr_q, addr_n;
  logic          blk_q, blk_n, sent_q, sent_n;
  logic          rv_q, rv_n, rc_q, rc_n;
  logic [7:0]    rd_q, rd_n;

  logic          is_rd, is_wr, is_blk, rearm, int_rd, cnt_rd, data_rd;
  logic [7:0]    reg_val, cnt_val;
  logic [LW-1:0] rem;

  assign is_rd   = cmd_valid && (cmd_op == OP_RD);
  assign is_wr   = cmd_valid && (cmd_op == OP_WR);
  assign is_blk  = cmd_valid && (cmd_op == OP_BLK) && (cmd_code == A_DATA);
  assign rearm   = is_wr && (cmd_code == A_STAT) && cmd_wdata[7];
  assign int_rd  = is_rd && (cmd_code == A_INT);
  assign cnt_rd  = blk_q && byte_req && !sent_q && !cmd_valid && !host_nack;
  assign data_rd = blk_q && byte_req && sent_q && !cmd_valid && !host_nack;

  assign rem     = (len_q > LW'(addr_q)) ? (len_q - LW'(addr_q)) : '0;
  assign cnt_val = (rem > LW'(CHUNK)) ? 8'(CHUNK) : 8'(rem);

  always_comb begin
    case (cmd_code)
      A_CTRL:  reg_val = ctrl_q;
      A_INT:   reg_val = {rxd_q || txd_q, 5'b0, txd_q, rxd_q};
      A_STAT:  reg_val = {en_q, 4'b0, fram_q || fcs_q, fcs_q, fram_q};
      A_LENLO: reg_val = 8'(len_q);
      A_LENHI: reg_val = 8'(len_q >> 8);
      A_ADDR:  reg_val = 8'(addr_q);
      default: reg_val = 8'h00;
    endcase
  end

  always_comb begin
    ctrl_n = ctrl_q;
    if (is_wr && cmd_code == A_CTRL) ctrl_n = cmd_wdata & 8'h83;

    rxd_n = rxd_q;
    if (end_pulse)   rxd_n = 1'b1;
    else if (int_rd) rxd_n = 1'b0;
    txd_n = txd_q;
    if (tx_done_set) txd_n = 1'b1;
    else if (int_rd) txd_n = 1'b0;

    en_n   = en_q;
    fram_n = fram_q;
    fcs_n  = fcs_q;
    len_n  = len_q;
    if (end_pulse) begin
      en_n   = 1'b0;
      fram_n = end_fram;
      fcs_n  = end_fcs;
      len_n  = end_len;
    end else if (rearm) begin
      en_n   = 1'b1;
      fram_n = 1'b0;
      fcs_n  = 1'b0;
    end

    addr_n = addr_q;
    if (rearm)                                addr_n = '0;
    else if (is_wr && cmd_code == A_ADDR)     addr_n = AW'(cmd_wdata);
    else if (data_rd)                         addr_n = addr_q + AW'(1);

    blk_n = blk_q;
    if (cmd_valid)      blk_n = is_blk;
    else if (host_nack) blk_n = 1'b0;
    sent_n = sent_q;
    if (is_blk)      sent_n = 1'b0;
    else if (cnt_rd) sent_n = 1'b1;

    rv_n = is_rd || cnt_rd || data_rd;
    rc_n = cnt_rd;
    rd_n = rd_q;
    if (is_rd)        rd_n = reg_val;
    else if (cnt_rd)  rd_n = cnt_val;
    else if (data_rd) rd_n = mem_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      rxd_q  <= 1'b0;
      txd_q  <= 1'b0;
      en_q   <= 1'b1;
      fram_q <= 1'b0;
      fcs_q  <= 1'b0;
      len_q  <= '0;
      addr_q <= '0;
      blk_q  <= 1'b0;
      sent_q <= 1'b0;
      rv_q   <= 1'b0;
      rc_q   <= 1'b0;
      rd_q   <= '0;
    end else begin
      ctrl_q <= ctrl_n;
      rxd_q  <= rxd_n;
      txd_q  <= txd_n;
      en_q   <= en_n;
      fram_q <= fram_n;
      fcs_q  <= fcs_n;
      len_q  <= len_n;
      addr_q <= addr_n;
      blk_q  <= blk_n;
      sent_q <= sent_n;
      rv_q   <= rv_n;
      rc_q   <= rc_n;
      rd_q   <= rd_n;
    end
  end

  assign rx_en     = en_q;
  assign rd_addr   = addr_q;
  assign rsp_valid = rv_q;
  assign rsp_data  = rd_q;
  assign irq = ctrl_q[CTRL_GIE] &&
               ((rxd_q && !ctrl_q[CTRL_RXM]) || (txd_q && !ctrl_q[CTRL_TXM]));

  // R2: a frame end from the store sets done and locks the buffer
  p_done_on_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
    end_pulse |=> (rxd_q && !en_q));
  // R6: re-arming opens the buffer and rewinds the pointer
  p_rearm_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rearm && !end_pulse) |=> (en_q && addr_q == '0));
  // R7: each data byte advances the pointer by one
  p_ptr_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    data_rd |=> addr_q == $past(addr_q) + AW'(1));
  // R8: a returned count never exceeds the chunk
  p_count_cap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rv_q && rc_q) |-> rd_q <= 8'(CHUNK));
  // R5: the length holds while the buffer stays locked
  p_lock_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !rearm) |=> $stable(len_q));
endmodule

// File: rtl/rxbuf_top.sv
module rxbuf_top #(
  parameter int unsigned DEPTH = 256,
  parameter int unsigned CHUNK = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_vld,
  input  logic [7:0] rx_byte,
  input  logic       rx_end,
  input  logic       rx_fram_err,
  input  logic       rx_fcs_err,
  input  logic       tx_done,
  input  logic       cmd_valid,
  input  logic [1:0] cmd_op,
  input  logic [7:0] cmd_code,
  input  logic [7:0] cmd_wdata,
  input  logic       byte_req,
  input  logic       host_nack,
  output logic       rsp_valid,
  output logic [7:0] rsp_data,
  output logic       irq
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned LW = $clog2(DEPTH + 1);

  logic [1:0]    rst_sync;
  logic          rst_s;
  logic          arm, end_pulse, end_fram, end_fcs;
  logic [LW-1:0] end_len;
  logic [AW-1:0] rd_addr;
  logic [7:0]    mem_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_s = rst_sync[1];

  rxbuf_store #(.DEPTH(DEPTH)) i_store (
    .clk(clk), .rst_n(rst_s), .arm(arm),
    .in_vld(rx_vld), .in_byte(rx_byte), .in_end(rx_end),
    .in_fram(rx_fram_err), .in_fcs(rx_fcs_err),
    .rd_addr(rd_addr), .rd_byte(mem_byte),
    .end_pulse(end_pulse), .end_len(end_len),
    .end_fram(end_fram), .end_fcs(end_fcs)
  );

  rxbuf_regs #(.DEPTH(DEPTH), .CHUNK(CHUNK)) i_regs (
    .clk(clk), .rst_n(rst_s),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_code(cmd_code),
    .cmd_wdata(cmd_wdata), .byte_req(byte_req), .host_nack(host_nack),
    .tx_done_set(tx_done), .end_pulse(end_pulse), .end_len(end_len),
    .end_fram(end_fram), .end_fcs(end_fcs), .mem_byte(mem_byte),
    .rx_en(arm), .rd_addr(rd_addr),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .irq(irq)
  );
endmodule

// File: tb/test_rxbuf_top.sv
module test_rxbuf_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       rx_vld, rx_end, rx_fram_err, rx_fcs_err, tx_done;
  logic [7:0] rx_byte;
  logic       cmd_valid, byte_req, host_nack;
  logic [1:0] cmd_op;
  logic [7:0] cmd_code, cmd_wdata;
  logic       rsp_valid, irq;
  logic [7:0] rsp_data;

  int n_chk = 0;
  int n_fail = 0;

  logic [7:0] exp_mem [256];
  int         exp_len;
  logic       exp_fram, exp_fcs, exp_en;

  always #2.5 clk = ~clk;

  rxbuf_top i_rxbuf_top (
    .clk(clk), .rst_n(rst_n), .rx_vld(rx_vld), .rx_byte(rx_byte),
    .rx_end(rx_end), .rx_fram_err(rx_fram_err), .rx_fcs_err(rx_fcs_err),
    .tx_done(tx_done), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_code(cmd_code), .cmd_wdata(cmd_wdata), .byte_req(byte_req),
    .host_nack(host_nack), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .irq(irq)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic int exp_count(input int len, input int addr);
    if (len <= addr) return 0;
    return (len - addr > 32) ? 32 : len - addr;
  endfunction

  function automatic int exp_stat();
    return (exp_en ? 8'h80 : 0) | ((exp_fram || exp_fcs) ? 4 : 0) |
           (exp_fcs ? 2 : 0) | (exp_fram ? 1 : 0);
  endfunction

  task automatic rd_reg(input logic [7:0] code, output logic [7:0] d);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'd0; cmd_code = code;
    @(negedge clk);
    cmd_valid = 1'b0;
    check("R11 read response valid", int'(rsp_valid), 1);
    d = rsp_data;
  endtask

  task automatic wr_reg(input logic [7:0] code, input logic [7:0] v);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'd1; cmd_code = code; cmd_wdata = v;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic send_frame(input int len, input logic fe, input logic ce);
    for (int i = 0; i < len; i++) begin
      logic [7:0] b;
      b = 8'($urandom);
      @(negedge clk);
      rx_vld = 1'b1; rx_byte = b;
      if (exp_en && i < 256) exp_mem[i] = b;
    end
    @(negedge clk);
    rx_vld = 1'b0; rx_end = 1'b1; rx_fram_err = fe; rx_fcs_err = ce;
    @(negedge clk);
    rx_end = 1'b0; rx_fram_err = 1'b0; rx_fcs_err = 1'b0;
    if (exp_en) begin
      exp_len  = (len > 256) ? 256 : len;
      exp_fram = fe || (len > 256);
      exp_fcs  = ce;
      exp_en   = 1'b0;
    end
  endtask

  task automatic blk_start();
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'd2; cmd_code = 8'h40;
    @(negedge clk);
    cmd_valid = 1'b0;
    check("R11 no response to block start", int'(rsp_valid), 0);
  endtask

  task automatic blk_byte(output logic [7:0] d);
    @(negedge clk);
    byte_req = 1'b1;
    @(negedge clk);
    byte_req = 1'b0;
    check("R8 block byte valid", int'(rsp_valid), 1);
    d = rsp_data;
  endtask

  task automatic blk_nack();
    @(negedge clk);
    host_nack = 1'b1;
    @(negedge clk);
    host_nack = 1'b0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] d;
    int addr;
    void'($urandom(32'd4242));
    rst_n = 1'b0; rx_vld = 0; rx_end = 0; rx_fram_err = 0; rx_fcs_err = 0;
    rx_byte = 0; tx_done = 0; cmd_valid = 0; cmd_op = 0; cmd_code = 0;
    cmd_wdata = 0; byte_req = 0; host_nack = 0;
    exp_en = 1'b1; exp_len = 0; exp_fram = 0; exp_fcs = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1 irq", int'(irq), 0);
    rd_reg(8'h3D, d); check("R1 status", d, 8'h80);
    rd_reg(8'h3C, d); check("R1 interrupt reg", d, 0);
    rd_reg(8'h3E, d); check("R1 length low", d, 0);
    rd_reg(8'h3A, d); check("R1 length high", d, 0);
    rd_reg(8'h3F, d); check("R1 pointer", d, 0);

    // R2/R3 frame with checksum error, interrupt enabled
    wr_reg(8'h3B, 8'h80);
    send_frame(40, 1'b0, 1'b1);
    check("R3 irq after frame", int'(irq), 1);
    rd_reg(8'h3D, d); check("R2 status after frame", d, exp_stat());
    rd_reg(8'h3E, d); check("R2 length", d, 40);

    // R4 interrupt read and clear
    rd_reg(8'h3C, d); check("R4 interrupt reg value", d, 8'h81);
    check("R4 irq cleared", int'(irq), 0);
    rd_reg(8'h3C, d); check("R4 done bits cleared", d, 0);

    // R5 locked buffer ignores a new frame
    send_frame(10, 1'b1, 1'b0);
    rd_reg(8'h3E, d); check("R5 length held", d, 40);
    rd_reg(8'h3D, d); check("R5 status held", d, exp_stat());
    rd_reg(8'h3C, d); check("R5 no new done", d, 0);

    // R8/R9 stream past the chunk, then resume
    blk_start();
    blk_byte(d); check("R8 first count", d, 32);
    for (int i = 0; i < 36; i++) begin
      blk_byte(d); check("R9 streamed data", d, exp_mem[i]);
    end
    blk_nack();
    blk_start();
    blk_byte(d); check("R9 resumed count", d, exp_count(40, 36));
    for (int i = 36; i < 40; i++) begin
      blk_byte(d); check("R9 resumed data", d, exp_mem[i]);
    end
    blk_nack();
    rd_reg(8'h3F, d); check("R7 pointer after reads", d, 40);

    // R7 pointer write and wrap
    wr_reg(8'h3F, 8'h05);
    blk_start();
    blk_byte(d); check("R8 count from 5", d, 32);
    blk_byte(d); check("R7 data at written pointer", d, exp_mem[5]);
    blk_nack();
    wr_reg(8'h3F, 8'hFE);
    blk_start();
    blk_byte(d); check("R8 count past length", d, 0);
    for (int i = 0; i < 3; i++) blk_byte(d);
    blk_nack();
    rd_reg(8'h3F, d); check("R7 pointer wrap", d, 1);

    // R6 re-arm
    wr_reg(8'h3D, 8'h7F);
    rd_reg(8'h3D, d); check("R6 write without bit7 ignored", d, exp_stat());
    wr_reg(8'h3D, 8'h80);
    exp_en = 1'b1; exp_fram = 0; exp_fcs = 0;
    rd_reg(8'h3D, d); check("R6 status after re-arm", d, 8'h80);
    rd_reg(8'h3F, d); check("R6 pointer cleared", d, 0);

    // R3 masks and transmit-done
    wr_reg(8'h3B, 8'h81);
    send_frame(5, 1'b0, 1'b0);
    check("R3 masked receive done", int'(irq), 0);
    @(negedge clk); tx_done = 1'b1;
    @(negedge clk); tx_done = 1'b0;
    check("R3 transmit done raises irq", int'(irq), 1);
    rd_reg(8'h3C, d); check("R4 both done bits", d, 8'h83);
    check("R4 irq dropped", int'(irq), 0);

    // R10 overflow
    wr_reg(8'h3D, 8'h80);
    exp_en = 1'b1; exp_fram = 0; exp_fcs = 0;
    send_frame(300, 1'b0, 1'b0);
    rd_reg(8'h3D, d); check("R10 framing on overflow", d, exp_stat());
    rd_reg(8'h3E, d); check("R10 length low", d, 0);
    rd_reg(8'h3A, d); check("R10 length high", d, 1);
    blk_start();
    blk_byte(d); check("R10 first count", d, 32);
    for (int i = 0; i < 256; i++) begin
      blk_byte(d); check("R10 stored data", d, exp_mem[i]);
    end
    blk_nack();
    rd_reg(8'h3F, d); check("R7 pointer wrapped to 0", d, 0);

    // random frames with random chunking
    for (int it = 0; it < 20; it++) begin
      int len;
      logic fe, ce;
      wr_reg(8'h3D, 8'h80);
      exp_en = 1'b1; exp_fram = 0; exp_fcs = 0;
      len = 1 + int'($urandom % 260);
      fe = 1'($urandom); ce = 1'($urandom);
      send_frame(len, fe, ce);
      rd_reg(8'h3D, d); check("R2 random status", d, exp_stat());
      rd_reg(8'h3E, d); check("R2 random length", d, exp_len & 8'hFF);
      addr = 0;
      while (addr < exp_len) begin
        int n;
        n = 1 + int'($urandom % 40);
        blk_start();
        blk_byte(d); check("R8 random count", d, exp_count(exp_len, addr));
        for (int k = 0; k < n && addr < exp_len; k++) begin
          blk_byte(d); check("R9 random data", d, exp_mem[addr]);
          addr++;
        end
        blk_nack();
      end
    end

    summary();
    $finish;
  end
endmodule